// File: doc/BRIEF.md
# Shift-Add Multiply-Accumulate Unit

This block multiplies two unsigned operands and adds the product into a running accumulator. It does this on every clock cycle. The multiplier does not use a behavioural `*` operator. Each row is the multiplicand gated by one multiplier bit and shifted left by that bit's position. A chain of ripple adders, one per row after the first, sums these rows. The adders are built from single-bit full-adder cells. One more ripple adder adds the product to the accumulator.

Both operands are captured in input registers. The accumulator register drives the output directly. With the default setting, a pair captured at clock edge N shows up in the output after edge N+1. A build parameter can cut the adder chain in half with a pipeline register. This shortens the longest combinational path, and the same pair then shows up after edge N+2.

Top module: `mac_shift_add`

## Requirements
- R1: While `rst` is high at a rising edge, the operand registers, the pipeline register and the accumulator are all cleared. After reset, `acc_o` reads 0.
- R2: With `PIPE_SPLIT=0`, a pair sampled at rising edge N adds `opa_i*opb_i` to `acc_o` at edge N+1. The output still holds its old value after edge N.
- R3: The sum wraps modulo 2^`ACC_W`. With the defaults, two 255×255 products accumulate to 64514.
- R4: Operands are unsigned. 255×255 adds 65025 (0xFE01).
- R5: A pair where either operand is zero leaves `acc_o` unchanged.
- R6: A reset edge discards any operand pair already captured but not yet accumulated. That pair is never added after reset is released.
- R7: A directed sequence drives every bit of `acc_o` to both 0 and 1.
- R8: With `PIPE_SPLIT=1`, a pair sampled at edge N changes `acc_o` at edge N+2, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opa_i | input | OP_W | Multiplicand, unsigned |
| opb_i | input | OP_W | Multiplier, unsigned |
| acc_o | output | ACC_W | Registered accumulator value |

## Verification
A reset can arrive in the same cycle that an operand pair is on its way to the accumulator. In that cycle, clearing and accumulating compete, and clearing must win. The bench captures a nonzero pair, then raises reset on the very next edge, before that pair could be added. The bench then checks that the accumulator reads zero and stays at zero for the following cycles. It does this for both the unsplit and the split instance. For the split instance, this proves the middle pipeline register was also flushed.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  parameter int unsigned MAC_OP_W  = 8;
  parameter int unsigned MAC_ACC_W = 16;
endpackage

// File: rtl/mac_fa_cell.sv
`timescale 1ns/1ps
module mac_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/mac_ripple_add.sv
`timescale 1ns/1ps
module mac_ripple_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  // carry out of the top bit is dropped: sum wraps modulo 2^W
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    mac_fa_cell u_fa (
      .a_i(a_i[i]),
      .b_i(b_i[i]),
      .c_i(cy[i]),
      .s_o(s_o[i]),
      .c_o(cy[i+1])
    );
  end

  assign s_o[W-1] = a_i[W-1] ^ b_i[W-1] ^ cy[W-1];
endmodule

// File: rtl/mac_pp_array.sv
`timescale 1ns/1ps
module mac_pp_array #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ACC_W = 16,
  parameter bit          SPLIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] prod_o
);
  // last row summed in the first stage when the chain is split
  localparam int unsigned CUT = OP_W / 2 - 1;

  logic [ACC_W-1:0]  pp   [OP_W];
  logic [ACC_W-1:0]  psum [OP_W];
  logic [OP_W-1:0]   a_late;
  logic [OP_W-1:CUT+1] b_late;
  logic [ACC_W-1:0]  mid;

  if (SPLIT) begin : g_split
    always_ff @(posedge clk) begin
      if (rst) begin
        a_late <= '0;
        b_late <= '0;
        mid    <= '0;
      end else begin
        a_late <= a_i;
        b_late <= b_i[OP_W-1:CUT+1];
        mid    <= psum[CUT];
      end
    end
  end else begin : g_flat
    assign a_late = a_i;
    assign b_late = b_i[OP_W-1:CUT+1];
    assign mid    = psum[CUT];
  end

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    if (i > CUT) begin : g_late
      assign pp[i] = b_late[i] ? (ACC_W'(a_late) << i) : '0;
    end else begin : g_early
      assign pp[i] = b_i[i] ? (ACC_W'(a_i) << i) : '0;
    end

    if (i == 0) begin : g_first
      assign psum[0] = pp[0];
    end else begin : g_add
      logic [ACC_W-1:0] chain_in;
      assign chain_in = (i - 1 == CUT) ? mid : psum[i-1];
      mac_ripple_add #(.W(ACC_W)) u_add (
        .a_i(chain_in),
        .b_i(pp[i]),
        .s_o(psum[i])
      );
    end
  end

  assign prod_o = psum[OP_W-1];

  // structural chain must match the arithmetic product of its operands
  if (SPLIT) begin : g_chk_split
    assert_product_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> prod_o == $past(ACC_W'(a_i) * ACC_W'(b_i)));
  end else begin : g_chk_flat
    assert_product_R2: assert property (@(posedge clk) disable iff (rst)
      prod_o == ACC_W'(a_i) * ACC_W'(b_i));
  end
endmodule

// File: rtl/mac_shift_add.sv
`timescale 1ns/1ps
module mac_shift_add
  import mac_pkg::*;
#(
  parameter int unsigned OP_W       = MAC_OP_W,
  parameter int unsigned ACC_W      = MAC_ACC_W,
  parameter bit          PIPE_SPLIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opa_i,
  input  logic [OP_W-1:0]  opb_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [OP_W-1:0]  a_q, b_q;
  logic [ACC_W-1:0] prod, acc_q, acc_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= opa_i;
      b_q <= opb_i;
    end
  end

  mac_pp_array #(.OP_W(OP_W), .ACC_W(ACC_W), .SPLIT(PIPE_SPLIT)) u_array (
    .clk(clk),
    .rst(rst),
    .a_i(a_q),
    .b_i(b_q),
    .prod_o(prod)
  );

  mac_ripple_add #(.W(ACC_W)) u_acc_add (
    .a_i(acc_q),
    .b_i(prod),
    .s_o(acc_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_sum;
  end

  assign acc_o = acc_q;

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_q == '0 && a_q == '0 && b_q == '0));

  assert_acc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    acc_sum == ACC_W'(acc_q + prod));

  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (prod == '0) |=> $stable(acc_q));
endmodule

// File: tb/sim_mac_shift_add.sv
`timescale 1ns/1ps
module sim_mac_shift_add;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opa = '0, opb = '0;
  logic [15:0] acc0, acc1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mac_shift_add u0 (.clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .acc_o(acc0));
  mac_shift_add #(.PIPE_SPLIT(1'b1)) u1 (.clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .acc_o(acc1));

  // reference model: one-edge and two-edge latency from sampling
  logic [15:0] m_p0, m_e0, m_p1a, m_p1b, m_e1;
  always @(posedge clk) begin
    if (rst) begin
      m_p0 <= '0; m_e0 <= '0; m_p1a <= '0; m_p1b <= '0; m_e1 <= '0;
    end else begin
      m_p0  <= {8'd0, opa} * {8'd0, opb};
      m_e0  <= m_e0 + m_p0;
      m_p1a <= {8'd0, opa} * {8'd0, opb};
      m_p1b <= m_p1a;
      m_e1  <= m_e1 + m_p1b;
    end
  end

  localparam logic [7:0] PA [12] = '{8'd255, 8'd2, 8'd1, 8'd17, 8'd200, 8'd9,
                                     8'd128, 8'd77, 8'd1, 8'd0, 8'd250, 8'd64};
  localparam logic [7:0] PB [12] = '{8'd255, 8'd255, 8'd1, 8'd13, 8'd150, 8'd9,
                                     8'd2, 8'd33, 8'd0, 8'd1, 8'd251, 8'd64};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] b);
    opa = a; opb = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; opa = '0; opb = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_R1();
    do_reset();
    chk("R1 flat", acc0, 16'd0);
    chk("R1 split", acc1, 16'd0);
    step(0, 0);
    chk("R1 flat hold", acc0, 16'd0);
  endtask

  task automatic t_latency_R2_R8();
    do_reset();
    step(3, 5);
    chk("R2 not before N+1", acc0, 16'd0);
    step(0, 0);
    chk("R2 at N+1", acc0, 16'd15);
    chk("R8 not before N+2", acc1, 16'd0);
    step(0, 0);
    chk("R8 at N+2", acc1, 16'd15);
    chk("R2 steady", acc0, 16'd15);
  endtask

  task automatic t_max_wrap_R4_R3();
    do_reset();
    step(255, 255);
    step(0, 0);
    chk("R4 flat", acc0, 16'd65025);
    step(0, 0);
    chk("R4 split", acc1, 16'd65025);
    step(255, 255);
    step(0, 0);
    chk("R3 flat wrap", acc0, 16'd64514);
    step(0, 0);
    chk("R3 split wrap", acc1, 16'd64514);
  endtask

  task automatic t_zero_R5();
    step(0, 200);
    step(200, 0);
    chk("R5 flat", acc0, 16'd64514);
    step(0, 0);
    step(0, 0);
    chk("R5 flat late", acc0, 16'd64514);
    chk("R5 split", acc1, 16'd64514);
  endtask

  task automatic t_flight_R6();
    do_reset();
    step(10, 10);
    step(0, 0);
    chk("R6 preload", acc0, 16'd100);
    step(7, 9);
    rst = 1'b1;
    step(0, 0);
    rst = 1'b0;
    step(0, 0);
    chk("R6 flat cleared", acc0, 16'd0);
    chk("R6 split cleared", acc1, 16'd0);
    step(0, 0);
    chk("R6 flat no late add", acc0, 16'd0);
    chk("R6 split no late add", acc1, 16'd0);
  endtask

  task automatic t_stream_R7();
    logic [15:0] seen1, seen0;
    do_reset();
    seen1 = acc0;
    seen0 = ~acc0;
    for (int i = 0; i < 12; i++) begin
      step(PA[i], PB[i]);
      chk("R2 stream flat", acc0, m_e0);
      chk("R8 stream split", acc1, m_e1);
      seen1 |= acc0;
      seen0 |= ~acc0;
    end
    for (int i = 0; i < 2; i++) begin
      step(0, 0);
      chk("R2 drain flat", acc0, m_e0);
      chk("R8 drain split", acc1, m_e1);
    end
    chk("R7 bits seen high", seen1, 16'hFFFF);
    chk("R7 bits seen low", seen0, 16'hFFFF);
  endtask

  initial begin
    t_reset_R1();
    t_latency_R2_R8();
    t_max_wrap_R4_R3();
    t_zero_R5();
    t_flight_R6();
    t_stream_R7();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule